// File: doc/BRIEF.md
# Serial EEPROM Read Slave (bit-banged two-wire)

This block models a small serial EEPROM that answers on a two-wire bus whose clock and data levels are written by a host one update at a time. Each update is marked by a one-cycle strobe, and the block compares the new levels with the levels it stored on the previous update. From that comparison it finds the bus conditions (a start, a stop, a clock rising edge with stable data) and steps a bit counter through a fixed sequence. First comes a command byte and an acknowledge slot. Then comes an address byte, during which the byte latched at the end of the previous transaction is shifted out, most significant bit first, if the command asked for a read. A second acknowledge slot closes the sequence.

At the end of the address byte the block loads the addressed byte from a read-only image into its data register. That byte is therefore returned during the address phase of the next read transaction. The image is a parameter. By default it is a memory-module presence-detect table of 256 bytes. The data level the block returns is whatever it stored on the last update: either the level the host wrote, or the level the slave forced onto the line.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset the returned data level `sda_ret` is 1, the counter is idle, and the data register holds 0x00, so the first read transaction shifts out eight 0 bits.
- R2: A start is an update with the clock high on both the previous and the new update while data falls from 1 to 0. It sets the bit count to 1 and clears the command register, even in the middle of a transaction.
- R3: A stop is an update with the clock high on both updates while data rises from 0 to 1. It changes no sequencing state: the bit count, the command and any pending acknowledge are kept.
- R4: While the count is idle (0) and no acknowledge is pending, every update other than a start leaves the sequencing state unchanged, and `sda_ret` equals the data level written.
- R5: A bit is taken only on a clock rising edge (clock 0 on the previous update, 1 on this update) when the data level equals the stored level. A rising edge on which data also changes is dropped and does not advance the count.
- R6: The first eight bits taken after a start are shifted into the command register, with the first bit ending up as the most significant bit. After the eighth bit an acknowledge is made pending. Command bit 0 equal to 1 selects read; 0 selects write.
- R7: When an acknowledge is pending, the next clock rising edge forces `sda_ret` to 0 and clears the pending acknowledge.
- R8: The next eight bits taken form the word address, first bit most significant. For a read command, each of those rising edges returns bit 7 of the data register on `sda_ret` and shifts the data register left by one. For a write command, `sda_ret` keeps the host's level.
- R9: On the eighth address bit the data register is loaded from the image at the 8-bit address that was just completed (0x00 to 0xFF all reachable), an acknowledge is made pending, and the count returns to idle.
- R10: The default image holds 0x80, 0x08, 0x04, 0x0D at addresses 0x00 to 0x03, 0x75 at 0x09, 0x8F at 0x10, 0x14 at 0x1B, 0x08 at 0x21, 0x12 at 0x3E, 0xF4 at 0x7F, and 0x00 at 0xFF.
- R11: Without an update strobe, no state changes and `sda_ret` holds its value whatever the clock and data inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_upd | input | 1 | One-cycle strobe: the host has written new line levels |
| scl_lvl | input | 1 | Bus clock level written by the host |
| sda_lvl | input | 1 | Bus data level written by the host |
| sda_ret | output | 1 | Data level stored on the last update, as seen by the host |

## Verification
The properties assume that the line inputs are only meaningful on a strobe, and that the host, after any rising edge on which the slave may have forced the data level, drops the clock before it writes new data. Without that rule, a held-high clock combined with a data value different from the forced level would read as a start or a stop. The stimulus drives every bit as a clock-low update followed by a clock-high update with the same data, and always lowers the clock next. It creates clock-high data changes only where a start, a stop or a dropped edge is intended. Strobes are one cycle wide, driven and sampled on the falling clock edge.

// File: rtl/i2cee_pkg.sv
package i2cee_pkg;

  localparam int BYTE_W    = 8;
  localparam int CNT_W     = 5;
  localparam int IMG_BYTES = 256;

  localparam logic [CNT_W-1:0] CNT_IDLE     = CNT_W'(0);
  localparam logic [CNT_W-1:0] CNT_FIRST    = CNT_W'(1);
  localparam logic [CNT_W-1:0] CNT_CMD_DONE = CNT_W'(BYTE_W + 1);
  localparam logic [CNT_W-1:0] CNT_ADR_DONE = CNT_W'(2 * BYTE_W + 1);

  typedef struct packed {
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] cmd;
    logic [BYTE_W-1:0] adr;
    logic [BYTE_W-1:0] dat;
    logic              ack;
  } eng_state_t;

  localparam logic [7:0] HEAD [0:36] = '{
    8'h80, 8'h08, 8'h04, 8'h0D, 8'h0A, 8'h01, 8'h40, 8'h00,
    8'h01, 8'h75, 8'h54, 8'h00, 8'h82, 8'h08, 8'h00, 8'h01,
    8'h8F, 8'h04, 8'h02, 8'h01, 8'h01, 8'h00, 8'h0E, 8'h00,
    8'h00, 8'h00, 8'h00, 8'h14, 8'h0F, 8'h14, 8'h2D, 8'h40,
    8'h15, 8'h08, 8'h15, 8'h08, 8'h00
  };

  function automatic logic [IMG_BYTES*BYTE_W-1:0] default_image();
    logic [IMG_BYTES*BYTE_W-1:0] img;
    img = '0;
    for (int i = 0; i < 37; i++) begin
      img[i*BYTE_W +: BYTE_W] = HEAD[i];
    end
    img[8'h3E*BYTE_W +: BYTE_W] = 8'h12;
    img[8'h3F*BYTE_W +: BYTE_W] = 8'hD0;
    img[8'h7E*BYTE_W +: BYTE_W] = 8'h64;
    img[8'h7F*BYTE_W +: BYTE_W] = 8'hF4;
    return img;
  endfunction

endpackage

// File: rtl/i2cee_line_sampler.sv
module i2cee_line_sampler (
  input  logic clk,
  input  logic rst_n,
  input  logic upd,
  input  logic scl_in,
  input  logic sda_in,
  input  logic sda_store,
  output logic scl_prev,
  output logic sda_prev,
  output logic ev_cond,
  output logic ev_rise,
  output logic ev_same
);

  logic scl_d, sda_d;

  always_comb begin
    scl_d = scl_prev;
    sda_d = sda_prev;
    if (upd) begin
      scl_d = scl_in;
      sda_d = sda_store;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_d;
      sda_prev <= sda_d;
    end
  end

  assign ev_same = (sda_prev == sda_in);
  assign ev_cond = scl_prev & scl_in & ~ev_same;
  assign ev_rise = ~scl_prev & scl_in;

endmodule

// File: rtl/i2cee_image_rom.sv
module i2cee_image_rom #(
  parameter int ADDR_W = 8,
  parameter logic [(1<<ADDR_W)*i2cee_pkg::BYTE_W-1:0] IMAGE = '0
) (
  input  logic [ADDR_W-1:0]              idx,
  output logic [i2cee_pkg::BYTE_W-1:0]   q
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [i2cee_pkg::BYTE_W-1:0] cells [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    assign cells[g] = IMAGE[g*i2cee_pkg::BYTE_W +: i2cee_pkg::BYTE_W];
  end

  assign q = cells[idx];

endmodule

// File: rtl/i2cee_bit_engine.sv
module i2cee_bit_engine
  import i2cee_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic              sda_in,
  input  logic              ev_cond,
  input  logic              ev_rise,
  input  logic              ev_same,
  input  logic [BYTE_W-1:0] rom_q,
  output logic [ADDR_W-1:0] rom_idx,
  output logic              sda_store,
  output eng_state_t        st_q
);

  eng_state_t        st_d;
  logic [BYTE_W-1:0] adr_shift;
  logic [CNT_W-1:0]  cnt_inc;

  assign adr_shift = {st_q.adr[BYTE_W-2:0], sda_in};
  assign cnt_inc   = st_q.cnt + CNT_W'(1);
  assign rom_idx   = adr_shift[ADDR_W-1:0];

  always_comb begin
    st_d      = st_q;
    sda_store = sda_in;
    if (upd) begin
      if (ev_cond) begin
        if (!sda_in) begin
          st_d.cnt = CNT_FIRST;
          st_d.cmd = '0;
        end
      end else if (st_q.cnt == CNT_IDLE && !st_q.ack) begin
        st_d = st_q;
      end else if (ev_rise) begin
        if (st_q.ack) begin
          sda_store = 1'b0;
          st_d.ack  = 1'b0;
        end else if (ev_same) begin
          if (st_q.cnt < CNT_CMD_DONE) begin
            st_d.cmd = {st_q.cmd[BYTE_W-2:0], sda_in};
            st_d.cnt = cnt_inc;
            if (cnt_inc == CNT_CMD_DONE) begin
              st_d.ack = 1'b1;
            end
          end else if (st_q.cnt < CNT_ADR_DONE) begin
            if (st_q.cmd[0]) begin
              sda_store = st_q.dat[BYTE_W-1];
            end
            st_d.adr = adr_shift;
            st_d.dat = {st_q.dat[BYTE_W-2:0], 1'b0};
            if (cnt_inc == CNT_ADR_DONE) begin
              st_d.dat = rom_q;
              st_d.ack = 1'b1;
              st_d.cnt = CNT_IDLE;
            end else begin
              st_d.cnt = cnt_inc;
            end
          end else begin
            sda_store = 1'b0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else if (upd) begin
      st_q <= st_d;
    end
  end

endmodule

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave
  import i2cee_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [(1<<ADDR_W)*BYTE_W-1:0] IMAGE = default_image()
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_upd,
  input  logic scl_lvl,
  input  logic sda_lvl,
  output logic sda_ret
);

  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic              scl_prev, sda_prev;
  logic              ev_cond, ev_rise, ev_same;
  logic              sda_store;
  logic [ADDR_W-1:0] rom_idx;
  logic [BYTE_W-1:0] rom_q;
  eng_state_t        eng_st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  i2cee_line_sampler u_lines (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .upd       (bus_upd),
    .scl_in    (scl_lvl),
    .sda_in    (sda_lvl),
    .sda_store (sda_store),
    .scl_prev  (scl_prev),
    .sda_prev  (sda_prev),
    .ev_cond   (ev_cond),
    .ev_rise   (ev_rise),
    .ev_same   (ev_same)
  );

  i2cee_bit_engine #(.ADDR_W(ADDR_W)) u_engine (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .upd       (bus_upd),
    .sda_in    (sda_lvl),
    .ev_cond   (ev_cond),
    .ev_rise   (ev_rise),
    .ev_same   (ev_same),
    .rom_q     (rom_q),
    .rom_idx   (rom_idx),
    .sda_store (sda_store),
    .st_q      (eng_st)
  );

  i2cee_image_rom #(.ADDR_W(ADDR_W), .IMAGE(IMAGE)) u_rom (
    .idx (rom_idx),
    .q   (rom_q)
  );

  assign sda_ret = sda_prev;

endmodule

// File: rtl/i2cee_checker.sv
module i2cee_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       upd,
  input logic       scl_in,
  input logic       sda_in,
  input logic       scl_prev,
  input logic       sda_out,
  input logic [4:0] cnt,
  input logic [7:0] cmd,
  input logic       ack
);

  logic cond_w, rise_w;
  assign cond_w = scl_prev && scl_in && (sda_out != sda_in);
  assign rise_w = !scl_prev && scl_in;

  // R2
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd && cond_w && !sda_in |=> cnt == 5'd1 && cmd == 8'h00);

  // R3
  stop_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd && cond_w && sda_in |=> $stable(cnt) && $stable(cmd) && $stable(ack) && sda_out);

  // R4
  idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd && cnt == 5'd0 && !ack && !cond_w |=> cnt == 5'd0 && !ack && sda_out == $past(sda_in));

  // R5
  glitch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd && rise_w && (sda_in != sda_out) && !ack |=> $stable(cnt) && $stable(cmd));

  // R6
  cmd_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd && rise_w && (sda_in == sda_out) && !ack && cnt == 5'd8 |=> ack && cnt == 5'd9);

  // R7
  ack_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd && rise_w && ack |=> !sda_out && !ack);

  // R9
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= 5'd16);

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(sda_out) && $stable(cnt) && $stable(ack));

endmodule

bind i2c_eeprom_slave i2cee_checker chk_i (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .upd      (bus_upd),
  .scl_in   (scl_lvl),
  .sda_in   (sda_lvl),
  .scl_prev (scl_prev),
  .sda_out  (sda_prev),
  .cnt      (eng_st.cnt),
  .cmd      (eng_st.cmd),
  .ack      (eng_st.ack)
);

// File: tb/i2c_eeprom_slave_tb_top.sv
`timescale 1ns/1ps
module i2c_eeprom_slave_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_upd = 1'b0;
  logic scl_lvl = 1'b1;
  logic sda_lvl = 1'b1;
  logic sda_ret;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  i2c_eeprom_slave dut_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .bus_upd (bus_upd),
    .scl_lvl (scl_lvl),
    .sda_lvl (sda_lvl),
    .sda_ret (sda_ret)
  );

  // {address, byte expected on the line during this read}
  localparam logic [15:0] VEC [0:6] = '{
    16'h0000, 16'h0380, 16'h7F0D, 16'h3EF4, 16'hFF12, 16'h0900, 16'h1075
  };

  task automatic check(input logic act, input logic exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: sda_ret=%0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic d, input logic e, input string tag);
    @(negedge clk);
    scl_lvl = s;
    sda_lvl = d;
    bus_upd = 1'b1;
    @(negedge clk);
    bus_upd = 1'b0;
    check(sda_ret, e, tag);
  endtask

  task automatic bitx(input logic b, input logic e_hi, input string tag);
    step(1'b0, b, b, tag);
    step(1'b1, b, e_hi, tag);
  endtask

  task automatic ackslot(input string tag);
    bitx(1'b1, 1'b0, tag);
  endtask

  task automatic start_c(input string tag);
    step(1'b1, 1'b0, 1'b0, tag);
  endtask

  task automatic stop_c(input string tag);
    step(1'b0, 1'b0, 1'b0, tag);
    step(1'b1, 1'b0, 1'b0, tag);
    step(1'b1, 1'b1, 1'b1, tag);
  endtask

  task automatic addr_phase(input logic [7:0] cmd, input logic [7:0] adr,
                            input logic [7:0] exp, input string tag);
    for (int i = 7; i >= 0; i--) begin
      bitx(adr[i], cmd[0] ? exp[i] : adr[i], tag);
    end
    ackslot({tag, " R9 ack"});
  endtask

  task automatic txn(input logic [7:0] cmd, input logic [7:0] adr,
                     input logic [7:0] exp, input int glitch_at, input string tag);
    start_c({tag, " R2"});
    for (int i = 7; i >= 0; i--) begin
      if (i == glitch_at) begin
        step(1'b0, 1'b0, 1'b0, {tag, " R5 glitch low"});
        step(1'b1, 1'b1, 1'b1, {tag, " R5 glitch high"});
      end
      bitx(cmd[i], cmd[i], {tag, " R6 cmd"});
    end
    ackslot({tag, " R7 ack"});
    addr_phase(cmd, adr, exp, {tag, " R8"});
    stop_c({tag, " R3 stop"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(sda_ret, 1'b1, "R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(sda_ret, 1'b1, "R1 after reset");

    // R4: clocking without a start must never produce an acknowledge
    for (int k = 0; k < 10; k++) begin
      bitx(1'b1, 1'b1, "R4 idle");
    end
    bitx(1'b0, 1'b0, "R4 idle low data");
    step(1'b0, 1'b1, 1'b1, "R4 idle");
    step(1'b1, 1'b1, 1'b1, "R4 idle");

    // R1 R9 R10: table of reads; each shows the byte latched by the previous one
    for (int v = 0; v < 7; v++) begin
      txn(8'hA1, VEC[v][15:8], VEC[v][7:0], -1, $sformatf("R10 vec%0d", v));
    end

    // R5: dropped edge inside the command byte
    txn(8'hA1, 8'h21, 8'h8F, 4, "R5 glitch txn");

    // R2: restart mid-command, then a write (R8: host level kept)
    start_c("R2 first start");
    bitx(1'b1, 1'b1, "R2 partial");
    bitx(1'b0, 1'b0, "R2 partial");
    bitx(1'b1, 1'b1, "R2 partial");
    bitx(1'b1, 1'b1, "R2 partial");
    start_c("R2 restart");
    for (int i = 7; i >= 0; i--) begin
      bitx(logic'((8'hA0 >> i) & 1), logic'((8'hA0 >> i) & 1), "R2 write cmd");
    end
    ackslot("R2 R6 ack after restart");
    addr_phase(8'hA0, 8'h1B, 8'h00, "R8 write addr");
    stop_c("R3 stop");

    // R3: stop in the middle of the command leaves the count
    start_c("R3 start");
    bitx(1'b1, 1'b1, "R3 cmd");
    bitx(1'b0, 1'b0, "R3 cmd");
    bitx(1'b1, 1'b1, "R3 cmd");
    bitx(1'b0, 1'b0, "R3 cmd");
    step(1'b0, 1'b0, 1'b0, "R3 bit");
    step(1'b1, 1'b0, 1'b0, "R3 bit");
    step(1'b1, 1'b1, 1'b1, "R3 mid stop");
    bitx(1'b0, 1'b0, "R3 cmd after stop");
    bitx(1'b0, 1'b0, "R3 cmd after stop");
    bitx(1'b1, 1'b1, "R3 cmd after stop");
    ackslot("R3 R7 ack kept count");
    addr_phase(8'hA1, 8'h05, 8'h14, "R3 R9 data from write txn");
    stop_c("R3 stop");

    txn(8'hA1, 8'h00, 8'h01, -1, "R10 addr05");

    // R11: no strobe, inputs that would form a start
    @(negedge clk);
    scl_lvl = 1'b1;
    sda_lvl = 1'b0;
    repeat (3) @(negedge clk);
    check(sda_ret, 1'b1, "R11 hold");
    sda_lvl = 1'b1;
    @(negedge clk);
    txn(8'hA1, 8'h03, 8'h80, -1, "R11 state kept");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule